// File: doc/BRIEF.md
# Coprocessor Mailbox Register Window

This block is the register window through which a host processor hands work to a security coprocessor. The host reaches it over a plain 32-bit read/write port. It decodes four word slots starting 0x70 bytes above a configurable base address. The slots hold a command word, a read-only status word and the two halves of a 64-bit pointer to a command/response buffer. The coprocessor side sees the pending command and the pointer as outputs. It raises and lowers status flags with per-bit strobes, and it clears the command word with a completion strobe.

The command word is also the busy indication. A nonzero value means a command is outstanding. The host first writes the pointer halves and then a nonzero command. That write sends a one-cycle new-command pulse to the coprocessor. The host then polls until the coprocessor has returned the command word to zero. A host attempt to issue a command while one is outstanding is dropped, and a sticky overrun output records it.

Top module: `cpmbx_top`

## Requirements
- R1: After a synchronous active-low reset, the command word, status flags, both pointer halves, read data, new-command pulse and overrun flag are all zero.
- R2: With the default base of zero, the slots are command at 0x70, status at 0x74, pointer low at 0x78 and pointer high at 0x7C. A write to any other address, including unaligned ones, changes nothing. A read of any other address returns zero.
- R3: Both pointer halves are host read/write. cp_ptr presents {high, low} from the clock edge of the write.
- R4: A host write of a nonzero value to the command slot while the command word is zero loads it. cp_cmd shows the value from that edge, and cp_new_cmd is high for exactly the one cycle after that edge.
- R5: A host write of zero to the command slot while the command word is zero leaves it zero and gives no pulse.
- R6: Any host write to the command slot while the command word is nonzero is ignored and gives no pulse. It sets cp_overrun, which stays set until reset.
- R7: cp_done while the command word is nonzero clears it at that edge. A host command write in the same cycle is treated as in R6.
- R8: The status slot is read-only from the host. Flag bit i (0 initialized, 1 error, 2 terminated, 3 halt, 4 recovery) is set by cp_set[i] and cleared by cp_clr[i], and set wins when both are high. Status bits 31 to 5 read zero.
- R9: Read data is registered. In the cycle after a read strobe, hst_rdata holds the slot value as it was before any write in the same cycle. In a cycle after no read, it holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 16 | Host byte address |
| hst_we | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered host read data |
| cp_set | input | 5 | Per-flag set strobes |
| cp_clr | input | 5 | Per-flag clear strobes |
| cp_done | input | 1 | Command completion strobe |
| cp_cmd | output | 32 | Current command word |
| cp_ptr | output | 64 | Buffer pointer {high, low} |
| cp_new_cmd | output | 1 | One-cycle new-command pulse |
| cp_overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following rules on every cycle:
- the new-command pulse lasts one cycle and only accompanies a nonzero command;
- a pending command holds until completion;
- completion clears a pending command;
- the overrun flag never falls;
- the pointer moves only on writes;
- the status upper bits and idle read data stay zero.

Only the bench's scenarios can show that a write lands in the right slot, and that a dropped write left the old command intact. The same holds for the set-over-clear priority on flags and for read data returning the pre-write value. These scenarios include the collision of completion with a host command write.

// File: rtl/cpmbx_pkg.sv
// Package: shared widths and slot numbering for the coprocessor mailbox.
// Assumes a 32-bit host data path and five lifecycle flags.
package cpmbx_pkg;
    localparam int HDATA_W = 32;
    localparam int NFLAG   = 5;
    localparam int NSLOT   = 4;

    // Slot order inside the window; the host software depends on it.
    typedef enum logic [1:0] {
        SLOT_CMD  = 2'd0,
        SLOT_STAT = 2'd1,
        SLOT_PLO  = 2'd2,
        SLOT_PHI  = 2'd3
    } slot_e;
endpackage

// File: rtl/cpmbx_decode.sv
// Module: address decoder for the mailbox window.
// Produces one-hot slot hits for word-aligned addresses BASE+WIN_OFF+4*i.
// Assumes the window does not wrap the address space.
module cpmbx_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16'h0070)
) (
    input  logic [ADDR_W-1:0]          addr,
    output logic [cpmbx_pkg::NSLOT-1:0] hit
);
    localparam logic [ADDR_W-1:0] WIN_BASE = BASE + WIN_OFF;

    // One comparator per slot
    for (genvar i = 0; i < cpmbx_pkg::NSLOT; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_A = WIN_BASE + ADDR_W'(4 * i);
        assign hit[i] = (addr == SLOT_A);
    end
endmodule

// File: rtl/cpmbx_cmd.sv
// Module: command word with busy semantics.
// Loads a nonzero host value only when idle, pulses the coprocessor once,
// records writes while busy as a sticky overrun, and clears on completion.
module cpmbx_cmd #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wdata,
    input  logic         done,
    output logic [W-1:0] cmd_o,
    output logic         pulse_o,
    output logic         ovr_o
);
    logic [W-1:0] cmd_q;
    logic         pulse_q;
    logic         ovr_q;
    logic         busy;
    logic         accept;
    logic         busy_wr;

    // Qualify the host write against the busy state
    always_comb begin
        busy    = (cmd_q != '0);
        accept  = wr_hit && !busy && (wdata != '0);
        busy_wr = wr_hit && busy;
    end

    // Command register, pulse and sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            pulse_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (accept)
                cmd_q <= wdata;
            else if (done)
                cmd_q <= '0;
            pulse_q <= accept;
            if (busy_wr)
                ovr_q <= 1'b1;
        end
    end

    assign cmd_o   = cmd_q;
    assign pulse_o = pulse_q;
    assign ovr_o   = ovr_q;
endmodule

// File: rtl/cpmbx_status.sv
// Module: lifecycle flag bank driven only from the coprocessor side.
// Each flag has its own set and clear strobe; set takes priority.
module cpmbx_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    // One flop per flag
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        // Set-dominant flag update
        always_ff @(posedge clk) begin
            if (!rst_n)
                f_q <= 1'b0;
            else if (set_i[i])
                f_q <= 1'b1;
            else if (clr_i[i])
                f_q <= 1'b0;
        end
        assign flags_o[i] = f_q;
    end
endmodule

// File: rtl/cpmbx_ptr.sv
// Module: buffer pointer held as host-writable halves.
// Assumes the host writes each half with a separate word access.
module cpmbx_ptr #(
    parameter int HALF_W = 32,
    parameter int NHALF  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NHALF-1:0]         wr_en,
    input  logic [HALF_W-1:0]        wdata,
    output logic [NHALF*HALF_W-1:0]  ptr_o
);
    // One register per half, lowest half first
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic [HALF_W-1:0] half_q;
        // Host write of this half
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_q <= '0;
            else if (wr_en[h])
                half_q <= wdata;
        end
        assign ptr_o[h*HALF_W +: HALF_W] = half_q;
    end
endmodule

// File: rtl/cpmbx_top.sv
// Module: coprocessor mailbox register window (top).
// Host side: 32-bit word read/write port with registered read data.
// Coprocessor side: flag strobes, completion strobe, command/pointer view.
// Assumes at most one host access per cycle; read and write may coincide.
module cpmbx_top #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16'h0070)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   hst_addr,
    input  logic                                hst_we,
    input  logic                                hst_rd,
    input  logic [cpmbx_pkg::HDATA_W-1:0]       hst_wdata,
    output logic [cpmbx_pkg::HDATA_W-1:0]       hst_rdata,
    input  logic [cpmbx_pkg::NFLAG-1:0]         cp_set,
    input  logic [cpmbx_pkg::NFLAG-1:0]         cp_clr,
    input  logic                                cp_done,
    output logic [cpmbx_pkg::HDATA_W-1:0]       cp_cmd,
    output logic [2*cpmbx_pkg::HDATA_W-1:0]     cp_ptr,
    output logic                                cp_new_cmd,
    output logic                                cp_overrun
);
    import cpmbx_pkg::*;

    localparam int PAD_W = HDATA_W - NFLAG;

    logic [NSLOT-1:0]   hit;
    logic [NFLAG-1:0]   flags;
    logic [HDATA_W-1:0] rd_mux;
    logic [HDATA_W-1:0] rdata_q;

    cpmbx_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_OFF(WIN_OFF)) u_dec (
        .addr (hst_addr),
        .hit  (hit)
    );

    cpmbx_cmd #(.W(HDATA_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (hst_we && hit[SLOT_CMD]),
        .wdata   (hst_wdata),
        .done    (cp_done),
        .cmd_o   (cp_cmd),
        .pulse_o (cp_new_cmd),
        .ovr_o   (cp_overrun)
    );

    cpmbx_status #(.N(NFLAG)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (cp_set),
        .clr_i   (cp_clr),
        .flags_o (flags)
    );

    cpmbx_ptr #(.HALF_W(HDATA_W), .NHALF(2)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en ({hst_we && hit[SLOT_PHI], hst_we && hit[SLOT_PLO]}),
        .wdata (hst_wdata),
        .ptr_o (cp_ptr)
    );

    // Select the addressed slot's current value; misses read zero
    always_comb begin
        rd_mux = '0;
        if (hit[SLOT_CMD])       rd_mux = cp_cmd;
        else if (hit[SLOT_STAT]) rd_mux = {{PAD_W{1'b0}}, flags};
        else if (hit[SLOT_PLO])  rd_mux = cp_ptr[HDATA_W-1:0];
        else if (hit[SLOT_PHI])  rd_mux = cp_ptr[2*HDATA_W-1:HDATA_W];
    end

    // Register read data; zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= hst_rd ? rd_mux : '0;
    end

    assign hst_rdata = rdata_q;
endmodule

// File: rtl/cpmbx_chk.sv
// Module: protocol checker for the mailbox, bound to cpmbx_top.
// Observes ports only; all properties are disabled during reset.
module cpmbx_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] WIN_OFF = ADDR_W'(16'h0070)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               hst_addr,
    input logic                            hst_we,
    input logic                            hst_rd,
    input logic [cpmbx_pkg::HDATA_W-1:0]   hst_rdata,
    input logic                            cp_done,
    input logic [cpmbx_pkg::HDATA_W-1:0]   cp_cmd,
    input logic [2*cpmbx_pkg::HDATA_W-1:0] cp_ptr,
    input logic                            cp_new_cmd,
    input logic                            cp_overrun
);
    import cpmbx_pkg::*;
    localparam logic [ADDR_W-1:0] STAT_A = BASE + WIN_OFF + ADDR_W'(4);

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_we |=> $stable(cp_ptr));
    p_pulse_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_new_cmd |-> (cp_cmd != '0));
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cp_new_cmd |=> !cp_new_cmd);
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cp_cmd != '0) && !cp_done) |=> $stable(cp_cmd));
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cp_overrun |=> cp_overrun);
    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_done && (cp_cmd != '0)) |=> (cp_cmd == '0));
    p_stat_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && (hst_addr == STAT_A)) |=> (hst_rdata[HDATA_W-1:NFLAG] == '0));
    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !hst_rd |=> (hst_rdata == '0));
endmodule

bind cpmbx_top cpmbx_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_OFF(WIN_OFF)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_addr   (hst_addr),
    .hst_we     (hst_we),
    .hst_rd     (hst_rd),
    .hst_rdata  (hst_rdata),
    .cp_done    (cp_done),
    .cp_cmd     (cp_cmd),
    .cp_ptr     (cp_ptr),
    .cp_new_cmd (cp_new_cmd),
    .cp_overrun (cp_overrun)
);

// File: tb/cpmbx_top_tb.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module cpmbx_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hst_addr = '0;
    logic        hst_we = 1'b0, hst_rd = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic [4:0]  cp_set = '0, cp_clr = '0;
    logic        cp_done = 1'b0;
    logic [31:0] cp_cmd;
    logic [63:0] cp_ptr;
    logic        cp_new_cmd, cp_overrun;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    cpmbx_top u_dut (.*);

    // Reference model state
    logic [31:0] m_cmd, m_lo, m_hi, m_rd, rv;
    logic [4:0]  m_st;
    logic        m_pulse, m_ovr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = 0; m_lo = 0; m_hi = 0; m_rd = 0; m_st = 0; m_pulse = 0; m_ovr = 0;
        end else begin
            rv = 0;
            case (hst_addr)
                16'h70: rv = m_cmd;
                16'h74: rv = {27'd0, m_st};
                16'h78: rv = m_lo;
                16'h7C: rv = m_hi;
                default: rv = 0;
            endcase
            m_rd = hst_rd ? rv : 0;
            m_pulse = 0;
            if (hst_we && hst_addr == 16'h70) begin
                if (m_cmd != 0) m_ovr = 1;
                else if (hst_wdata != 0) begin m_cmd = hst_wdata; m_pulse = 1; end
            end
            if (cp_done && !m_pulse) m_cmd = 0;
            if (hst_we && hst_addr == 16'h78) m_lo = hst_wdata;
            if (hst_we && hst_addr == 16'h7C) m_hi = hst_wdata;
            m_st = (m_st & ~cp_clr) | cp_set;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cmp_model();
        check("R4/R6/R7 model cp_cmd", 64'(cp_cmd), 64'(m_cmd));
        check("R3 model cp_ptr", cp_ptr, {m_hi, m_lo});
        check("R4 model cp_new_cmd", 64'(cp_new_cmd), 64'(m_pulse));
        check("R6 model cp_overrun", 64'(cp_overrun), 64'(m_ovr));
        check("R9 model hst_rdata", 64'(hst_rdata), 64'(m_rd));
    endtask

    task automatic step(input logic [15:0] a, input logic we, input logic rd,
                        input logic [31:0] wd, input logic [4:0] s, input logic [4:0] c,
                        input logic dn);
        hst_addr = a; hst_we = we; hst_rd = rd; hst_wdata = wd;
        cp_set = s; cp_clr = c; cp_done = dn;
        @(posedge clk);
        @(negedge clk);
        cmp_model();
        hst_we = 0; hst_rd = 0; cp_set = 0; cp_clr = 0; cp_done = 0;
    endtask

    task automatic idle(); step(16'h0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr(input logic [15:0] a, input logic [31:0] d); step(a, 1, 0, d, 0, 0, 0); endtask
    task automatic rd(input logic [15:0] a); step(a, 0, 1, 0, 0, 0, 0); endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle();
        check("R1 cmd", 64'(cp_cmd), 0);
        check("R1 ptr", cp_ptr, 0);
        check("R1 overrun/pulse", {62'd0, cp_overrun, cp_new_cmd}, 0);
        rd(16'h74); check("R1 status read", 64'(hst_rdata), 0);
        // R3 pointer halves
        wr(16'h78, 32'hDEAD_0001);
        check("R3 ptr low edge", cp_ptr, 64'h0000_0000_DEAD_0001);
        wr(16'h7C, 32'hCAFE_0002);
        rd(16'h7C); check("R3 read high", 64'(hst_rdata), 64'hCAFE_0002);
        check("R3 cp_ptr", cp_ptr, 64'hCAFE_0002_DEAD_0001);
        // R4 issue command
        wr(16'h70, 32'h11);
        check("R4 cmd loaded", 64'(cp_cmd), 64'h11);
        check("R4 pulse high", 64'(cp_new_cmd), 1);
        idle(); check("R4 pulse one cycle", 64'(cp_new_cmd), 0);
        // R6 write while busy
        wr(16'h70, 32'h22);
        check("R6 cmd kept", 64'(cp_cmd), 64'h11);
        check("R6 no pulse", 64'(cp_new_cmd), 0);
        check("R6 overrun set", 64'(cp_overrun), 1);
        // R7 completion
        step(16'h0, 0, 0, 0, 0, 0, 1);
        check("R7 cleared", 64'(cp_cmd), 0);
        check("R6 overrun sticky", 64'(cp_overrun), 1);
        // R5 write zero when idle
        wr(16'h70, 32'h0);
        check("R5 no load", 64'(cp_cmd), 0);
        check("R5 no pulse", 64'(cp_new_cmd), 0);
        // R7 collision: busy, done and host write together
        wr(16'h70, 32'h33); idle();
        step(16'h70, 1, 0, 32'h44, 0, 0, 1);
        check("R7 collision cleared", 64'(cp_cmd), 0);
        check("R7 collision no pulse", 64'(cp_new_cmd), 0);
        // R8 status flags
        step(16'h0, 0, 0, 0, 5'b10101, 0, 0);
        step(16'h74, 1, 0, 32'hFFFF_FFFF, 5'b00001, 5'b00011, 0);
        rd(16'h74);
        check("R8 set wins, host write ignored", 64'(hst_rdata), 64'h15);
        step(16'h0, 0, 0, 0, 0, 5'b11111, 0);
        rd(16'h74); check("R8 cleared", 64'(hst_rdata), 0);
        // R2 decode misses
        wr(16'h80, 32'h5555); wr(16'h79, 32'h6666); wr(16'h71, 32'h77);
        check("R2 no stray write ptr", cp_ptr, 64'hCAFE_0002_DEAD_0001);
        check("R2 no stray write cmd", 64'(cp_cmd), 0);
        rd(16'h6C); check("R2 miss reads zero", 64'(hst_rdata), 0);
        // R9 read sees pre-write value
        step(16'h78, 1, 1, 32'h1234_5678, 0, 0, 0);
        check("R9 old value", 64'(hst_rdata), 64'hDEAD_0001);
        // Random traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            case ($urandom_range(0, 6))
                0: a = 16'h70; 1: a = 16'h74; 2: a = 16'h78; 3: a = 16'h7C;
                4: a = 16'h80; 5: a = 16'h6C; default: a = 16'h72;
            endcase
            step(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom,
                 5'($urandom), 5'($urandom), ($urandom_range(0, 3) == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule